// File: doc/BRIEF.md
# Bulk-Out Receive Buffer Writer with Packet Rollback

This block sits between a USB bulk-out endpoint and the byte RAM that holds outbound network traffic. Bytes from the endpoint go straight into the RAM as they arrive. There is no staging buffer. The block keeps two pointers. The write pointer moves with every accepted byte. The commit pointer is the only position the downstream frame extractor can see.

A packet that ends cleanly moves the commit pointer up to the write pointer. A packet that is marked bad moves the write pointer back to the commit pointer instead, so its bytes are overwritten later and are never seen downstream. A packet is bad when the endpoint raises the error strobe, when the buffer overflows part-way through, or when it is cut off by a new start strobe.

The downstream extractor returns its read pointer. From this the block reports the committed byte level and a ready flag. The endpoint uses the ready flag to NAK when there is no room for a maximum-size packet. Frame boundaries inside the committed bytes are not examined, so one frame per packet and several frames per packet are both handled the same way.

Top module: `bulk_out_rx`

## Requirements
- R1: After reset, commit_ptr and level are 0, ready is 1 and mem_we is 0.
- R2: Each byte with in_valid inside an open packet sets mem_we in the same cycle. It is written at consecutive addresses, starting at the commit pointer's RAM address.
- R3: When in_eop ends a packet with no error, commit_ptr takes the packet's end position from the next cycle on. This includes a byte that arrives in the eop cycle. level rises by the packet's byte count.
- R4: If in_err pulses at any cycle of a packet, including the eop cycle, commit_ptr is unchanged after eop. The next packet's first byte goes to the same address as the discarded packet's first byte.
- R5: A byte that arrives when written-but-unread bytes (write pointer minus rd_ptr) equal the buffer depth is not written (mem_we low), and its packet is rolled back at eop.
- R6: ready is 1 exactly when depth minus level is at least MAX_PKT.
- R7: in_valid outside a packet, or in the in_sop cycle, writes nothing and leaves commit_ptr unchanged.
- R8: An in_sop while a packet is open discards that packet. The new packet starts writing at the commit pointer.
- R9: Pointers are ADDR_W+1 bits and wrap modulo twice the depth. The RAM address is the low ADDR_W bits, so writes wrap from the top address to 0. level is commit_ptr minus rd_ptr modulo 2^(ADDR_W+1).
- R10: While a packet is open, commit_ptr and level do not move until its eop, unless rd_ptr changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sop | input | 1 | Packet start strobe (carries no byte) |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Byte value |
| in_eop | input | 1 | Packet end strobe; a byte may accompany it |
| in_err | input | 1 | Packet error strobe |
| rd_ptr | input | ADDR_W+1 | Read position of the frame extractor |
| ready | output | 1 | Room for a maximum-size packet |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM write address |
| mem_wdata | output | 8 | RAM write data |
| commit_ptr | output | ADDR_W+1 | Last committed position |
| level | output | ADDR_W+1 | Committed bytes not yet read |

## Verification
The bench builds the block with ADDR_W=5 and MAX_PKT=8, which gives a 32-byte buffer. At that size a few short packets are enough to clear the ready threshold. One longer packet then runs the buffer into overflow part-way through. A following packet crosses the top address, so address wrap and pointer wrap are both checked against values the bench computes itself.

// File: rtl/bor_pkg.sv
package bor_pkg;

    typedef struct packed {
        logic open;
        logic bad;
    } pkt_state_t;

    typedef enum logic [1:0] {
        PA_HOLD   = 2'd0,
        PA_COMMIT = 2'd1,
        PA_REWIND = 2'd2
    } ptr_action_t;

    function automatic logic pkt_clean(input pkt_state_t s, input logic err_now,
                                       input logic drop_now);
        return !(s.bad || err_now || drop_now);
    endfunction

endpackage

// File: rtl/bor_tracker.sv
module bor_tracker
    import bor_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sop,
    input  logic        eop,
    input  logic        err,
    input  logic        valid,
    input  logic        full,
    output logic        accept,
    output ptr_action_t act,
    output logic        open_o
);
    pkt_state_t st, st_nx;
    logic       drop_now;
    logic       finish;

    assign drop_now = st.open && valid && full && !sop;
    assign accept   = st.open && valid && !full && !sop;
    assign finish   = st.open && eop && !sop;
    assign open_o   = st.open;

    always_comb begin
        act = PA_HOLD;
        if (sop && st.open)
            act = PA_REWIND;
        else if (finish)
            act = pkt_clean(st, err, drop_now) ? PA_COMMIT : PA_REWIND;
    end

    always_comb begin
        st_nx = st;
        if (sop) begin
            st_nx.open = 1'b1;
            st_nx.bad  = 1'b0;
        end else if (finish) begin
            st_nx.open = 1'b0;
            st_nx.bad  = 1'b0;
        end else if (st.open) begin
            st_nx.bad = st.bad || err || drop_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nx;
    end

    // R4
    err_marks_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (st.open && err && !eop && !sop) |=> (act != PA_COMMIT));

endmodule

// File: rtl/bor_ptrs.sv
module bor_ptrs
    import bor_pkg::*;
#(
    parameter int ADDR_W = 13,
    localparam int PW = ADDR_W + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  ptr_action_t   act,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] commit_ptr
);
    logic [PW-1:0] wr_step;

    assign wr_step = wr_ptr + PW'(accept);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            commit_ptr <= '0;
        end else begin
            unique case (act)
                PA_COMMIT: begin
                    wr_ptr     <= wr_step;
                    commit_ptr <= wr_step;
                end
                PA_REWIND: wr_ptr <= commit_ptr;
                default:   wr_ptr <= wr_step;
            endcase
        end
    end

    // R2
    wr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (act == PA_HOLD && accept) |=> (wr_ptr == $past(wr_ptr) + PW'(1)));

    // R3
    commit_only_on_end_chk: assert property (@(posedge clk) disable iff (rst)
        (act != PA_COMMIT) |=> $stable(commit_ptr));

    // R4
    rewind_restores_chk: assert property (@(posedge clk) disable iff (rst)
        (act == PA_REWIND) |=> (wr_ptr == commit_ptr));

endmodule

// File: rtl/bor_space.sv
module bor_space #(
    parameter int ADDR_W  = 13,
    parameter int MAX_PKT = 512,
    localparam int PW = ADDR_W + 1,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] commit_ptr,
    input  logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] level,
    output logic          full,
    output logic          ready
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] MAXP_P  = PW'(MAX_PKT);

    logic [PW-1:0] used;

    assign level = commit_ptr - rd_ptr;
    assign used  = wr_ptr - rd_ptr;
    assign full  = (used == DEPTH_P);
    assign ready = (DEPTH_P - level) >= MAXP_P;

    // R5
    used_bound_chk: assert final (used <= DEPTH_P || $isunknown(used));

endmodule

// File: rtl/bulk_out_rx.sv
module bulk_out_rx
    import bor_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int MAX_PKT = 512,
    localparam int PW = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_sop,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_eop,
    input  logic              in_err,
    input  logic [PW-1:0]     rd_ptr,
    output logic              ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [PW-1:0]     commit_ptr,
    output logic [PW-1:0]     level
);
    localparam int DEPTH = 1 << ADDR_W;

    logic          accept;
    logic          full;
    logic          pkt_open;
    ptr_action_t   act;
    logic [PW-1:0] wr_ptr;

    bor_tracker u_trk (
        .clk    (clk),
        .rst    (rst),
        .sop    (in_sop),
        .eop    (in_eop),
        .err    (in_err),
        .valid  (in_valid),
        .full   (full),
        .accept (accept),
        .act    (act),
        .open_o (pkt_open)
    );

    bor_ptrs #(.ADDR_W(ADDR_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .act        (act),
        .wr_ptr     (wr_ptr),
        .commit_ptr (commit_ptr)
    );

    bor_space #(.ADDR_W(ADDR_W), .MAX_PKT(MAX_PKT)) u_spc (
        .wr_ptr     (wr_ptr),
        .commit_ptr (commit_ptr),
        .rd_ptr     (rd_ptr),
        .level      (level),
        .full       (full),
        .ready      (ready)
    );

    assign mem_we    = accept;
    assign mem_addr  = wr_ptr[ADDR_W-1:0];
    assign mem_wdata = in_data;

    // R5
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !mem_we);

    // R7
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!pkt_open || in_sop) |-> !mem_we);

    // R4
    err_end_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_open && in_eop && in_err && !in_sop) |=> $stable(commit_ptr));

    // R10
    open_commit_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_open && !in_eop) |=> $stable(commit_ptr));

    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= PW'(DEPTH));

endmodule

// File: tb/tb_bulk_out_rx.sv
`timescale 1ns/1ps
module tb_bulk_out_rx;
    localparam int ADDR_W  = 5;
    localparam int MAX_PKT = 8;
    localparam int PW      = ADDR_W + 1;
    localparam int DEPTH   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_sop, in_valid, in_eop, in_err;
    logic [7:0]        in_data;
    logic [PW-1:0]     rd_ptr;
    logic              ready, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [PW-1:0]     commit_ptr, level;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bulk_out_rx #(.ADDR_W(ADDR_W), .MAX_PKT(MAX_PKT)) dut (
        .clk(clk), .rst(rst), .in_sop(in_sop), .in_valid(in_valid),
        .in_data(in_data), .in_eop(in_eop), .in_err(in_err), .rd_ptr(rd_ptr),
        .ready(ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .commit_ptr(commit_ptr), .level(level)
    );

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        in_sop = 0; in_valid = 0; in_eop = 0; in_err = 0; in_data = 8'h00;
    endtask

    task automatic start_pkt();
        in_sop = 1;
        step();
        in_sop = 0;
    endtask

    // one byte; exp_we/exp_addr checked combinationally in the same cycle
    task automatic put(input logic [7:0] d, input bit exp_we, input int exp_addr,
                       input bit last, input bit err, input string tag);
        in_valid = 1; in_data = d; in_eop = last; in_err = err;
        #1;
        chk(int'(mem_we), int'(exp_we), {tag, " mem_we"});
        if (exp_we) begin
            chk(int'(mem_addr), exp_addr % DEPTH, {tag, " mem_addr"});
            chk(int'(mem_wdata), int'(d), {tag, " mem_wdata"});
        end
        step();
        idle_inputs();
    endtask

    task automatic t_reset();
        rst = 1; rd_ptr = '0; idle_inputs();
        step(); step();
        rst = 0;
        step();
        chk(int'(commit_ptr), 0, "R1 commit_ptr");
        chk(int'(level), 0, "R1 level");
        chk(int'(ready), 1, "R1 ready");
        chk(int'(mem_we), 0, "R1 mem_we");
    endtask

    task automatic t_good();
        start_pkt();
        for (int i = 0; i < 4; i++) begin
            put(8'h10 + 8'(i), 1, i, 0, 0, "R2 good byte");
            chk(int'(commit_ptr), 0, "R10 commit during packet");
        end
        put(8'h14, 1, 4, 1, 0, "R3 byte with eop");
        chk(int'(commit_ptr), 5, "R3 commit after eop");
        chk(int'(level), 5, "R3 level after eop");
    endtask

    task automatic t_err_mid();
        start_pkt();
        put(8'hA0, 1, 5, 0, 0, "R4 bad pkt b0");
        put(8'hA1, 1, 6, 0, 1, "R4 bad pkt b1 err");
        put(8'hA2, 1, 7, 0, 0, "R4 bad pkt b2");
        in_eop = 1; step(); in_eop = 0;
        chk(int'(commit_ptr), 5, "R4 commit after errored pkt");
        start_pkt();
        put(8'hB0, 1, 5, 0, 0, "R4 restart address");
        put(8'hB1, 1, 6, 1, 0, "R4 restart b1");
        chk(int'(commit_ptr), 7, "R3 commit after retry");
    endtask

    task automatic t_err_at_eop();
        start_pkt();
        put(8'hC0, 1, 7, 0, 0, "R4 eop-err b0");
        put(8'hC1, 1, 8, 1, 1, "R4 eop-err b1");
        chk(int'(commit_ptr), 7, "R4 commit after err at eop");
        chk(int'(level), 7, "R4 level after err at eop");
    endtask

    task automatic t_outside();
        put(8'hEE, 0, 0, 0, 0, "R7 byte with no packet");
        chk(int'(commit_ptr), 7, "R7 commit after stray byte");
        in_sop = 1; in_valid = 1; in_data = 8'hEF; #1;
        chk(int'(mem_we), 0, "R7 byte in sop cycle");
        step(); idle_inputs();
        put(8'hD0, 1, 7, 1, 0, "R7 first byte after sop");
        chk(int'(commit_ptr), 8, "R7 commit after short pkt");
    endtask

    task automatic t_resync();
        start_pkt();
        put(8'h50, 1, 8, 0, 0, "R8 abandoned b0");
        put(8'h51, 1, 9, 0, 0, "R8 abandoned b1");
        start_pkt();
        chk(int'(commit_ptr), 8, "R8 commit after abandon");
        put(8'h60, 1, 8, 0, 0, "R8 new pkt start");
        put(8'h61, 1, 9, 1, 0, "R8 new pkt end");
        chk(int'(commit_ptr), 10, "R8 commit after new pkt");
    endtask

    task automatic t_ready();
        chk(int'(ready), 1, "R6 ready with level 10");
        start_pkt();
        for (int i = 0; i < 15; i++)
            put(8'(i), 1, 10 + i, i == 14, 0, "R6 fill byte");
        chk(int'(level), 25, "R6 level 25");
        chk(int'(ready), 0, "R6 not ready, free 7");
        rd_ptr = PW'(1); #1;
        chk(int'(ready), 1, "R6 ready, free 8");
        rd_ptr = PW'(20); #1;
        chk(int'(level), 5, "R9 level after read advance");
    endtask

    task automatic t_overflow();
        // rd=20, commit=25: 27 bytes fit before used reaches 32
        start_pkt();
        for (int i = 0; i < 30; i++)
            put(8'h80 + 8'(i), i < 27, 25 + i, i == 29, 0, "R5 overflow byte");
        chk(int'(commit_ptr), 25, "R5 commit after overflow");
        chk(int'(level), 5, "R5 level after overflow");
    endtask

    task automatic t_wrap();
        start_pkt();
        for (int i = 0; i < 10; i++)
            put(8'h30 + 8'(i), 1, 25 + i, i == 9, 0, "R9 wrap byte");
        chk(int'(commit_ptr), 35, "R9 commit wraps past depth");
        chk(int'(level), 15, "R9 level across wrap");
        rd_ptr = PW'(35); #1;
        chk(int'(level), 0, "R9 level drained");
        chk(int'(ready), 1, "R6 ready when empty");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_good();
        t_err_mid();
        t_err_at_eop();
        t_outside();
        t_resync();
        t_ready();
        t_overflow();
        t_wrap();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule